// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Controller

This block is the interrupt and status section of an SPI controller. It watches the occupancy of the transmit and receive FIFOs, takes strobes for receive overflow and for each word pushed into the receive FIFO, and turns them into four interrupt sources, a status word and one interrupt line. The FIFOs and the shifter sit outside. They present their fill levels and event strobes as plain ports, and the shifter drives a busy flag.

Four write strobes share one data bus. The threshold write sets a 3-bit logarithmic trigger code for each FIFO. The mask write selects which sources reach the interrupt line. The clear write acknowledges the two sticky event bits. The timeout write sets how many idle cycles mark a receive timeout. The two level sources follow FIFO occupancy directly and need no acknowledgement. The overflow and timeout sources latch and stay set until cleared.

A three-state machine detects the receive timeout. The states are `TM_EMPTY` (the receive FIFO is empty), `TM_ARMED` (words are waiting and the counter runs) and `TM_FIRED` (a timeout has been reported for this idle stretch). Its transitions are:
- empty at any edge: to `TM_EMPTY`, counter cleared.
- push while non-empty: to `TM_ARMED`, counter cleared.
- quiet edge with the limit reached, from `TM_EMPTY` or `TM_ARMED`: to `TM_FIRED`.
- quiet edge below the limit: to `TM_ARMED`, counter plus one.
- quiet edge in `TM_FIRED`: stays in `TM_FIRED`.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the sticky bits are 0, `mask_q` is 4'hF, `irq` is 0, the TX code is 5, the RX code is 3 and the timeout limit is 32.
- R2: Source bit positions are 0 receive overflow, 1 receive timeout, 2 receive level and 3 transmit level. `irq_stat` equals `raw_stat` AND NOT `mask_q`. A mask bit of 1 blocks its source. `mask_we` loads `wdata[3:0]` into `mask_q` at the next edge.
- R3: `irq` is 1 exactly when any bit of `irq_stat` is 1. With all four mask bits set, `irq` is 0.
- R4: `clr_we` with `wdata[0]` clears the overflow bit and with `wdata[1]` clears the timeout bit, at the next edge. Bits 2 and 3 are unaffected by clear writes.
- R5: An `rx_overflow` pulse sets raw bit 0 at the next edge, and the bit holds until cleared. If a set and a clear hit the same bit at the same edge, the set wins.
- R6: `thr_we` loads the TX code from `wdata[5:3]` and the RX code from `wdata[11:9]`. The new codes apply from the next cycle. Codes 0..7 mean 1, 4, 8, 16, 32, 64, 128 and 256 entries.
- R7: Raw bit 3 is 1 while `tx_level` is at or below the TX threshold.
- R8: Raw bit 2 is 1 while `rx_level` is at or above the RX threshold.
- R9: An edge is quiet when `rx_level` is non-zero and `rx_push` is 0. Raw bit 1 sets at the Nth consecutive quiet edge, where N is the limit. Any push edge or empty edge restarts the count. After a timeout fires, it does not fire again until a push edge or an empty edge has occurred.
- R10: `tmo_we` loads the timeout limit N from `wdata[15:0]` at the next edge.
- R11: `stat` bit 0 is `tx_level`==0, bit 1 is `tx_level`!=256, bit 2 is `rx_level`!=0, bit 3 is `rx_level`==256 and bit 4 is `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 9 | Transmit FIFO occupancy, 0..256 |
| rx_level | input | 9 | Receive FIFO occupancy, 0..256 |
| rx_push | input | 1 | A word entered the receive FIFO this cycle |
| rx_overflow | input | 1 | Receive overflow event strobe |
| busy | input | 1 | Shifter busy flag |
| thr_we | input | 1 | Write threshold codes |
| mask_we | input | 1 | Write interrupt mask |
| clr_we | input | 1 | Write sticky-bit clear |
| tmo_we | input | 1 | Write timeout limit |
| wdata | input | 16 | Write data shared by the four write strobes |
| raw_stat | output | 4 | Raw interrupt sources |
| irq_stat | output | 4 | Masked interrupt sources |
| mask_q | output | 4 | Current mask |
| stat | output | 5 | FIFO and busy status |
| irq | output | 1 | Interrupt line |

## Verification
Every threshold code is driven with FIFO levels one below, at and one above its entry count. This separates at-or-below from strictly-below and at-or-above from strictly-above, and shows that code 7 decodes to full depth. Set-and-clear collisions on the overflow bit, and clears applied while level sources are active, tell the set-wins order apart and show that clears do not reach the level bits. Timeout runs of N-1 and N quiet edges, at the default limit and at a programmed limit, locate the firing edge exactly and confirm one report per idle stretch. Random traffic with biased levels, sparse pushes and random register writes then exercises masking and the interrupt line against a bench model.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;

    localparam int SRC_N    = 4;
    localparam int SRC_ROVF = 0;
    localparam int SRC_RTMO = 1;
    localparam int SRC_RLVL = 2;
    localparam int SRC_TLVL = 3;

    localparam int CODE_W  = 3;
    localparam int TXC_LSB = 3;
    localparam int RXC_LSB = 9;

    localparam logic [CODE_W-1:0] TXC_RST = 3'd5;
    localparam logic [CODE_W-1:0] RXC_RST = 3'd3;

    typedef enum logic [1:0] {
        TM_EMPTY = 2'd0,
        TM_ARMED = 2'd1,
        TM_FIRED = 2'd2
    } tmo_state_e;

    // Code 0 means one entry; code k>0 means 2^(k+1) entries.
    function automatic logic [31:0] thr_entries(input logic [CODE_W-1:0] code);
        if (code == '0) begin
            return 32'd1;
        end
        return 32'd1 << (32'(code) + 32'd1);
    endfunction

endpackage

// File: rtl/spi_irq_cfg.sv
`timescale 1ns/1ps
module spi_irq_cfg
    import spi_irq_pkg::*;
#(
    parameter int WD_W    = 16,
    parameter int TMO_RST = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic              mask_we,
    input  logic              tmo_we,
    input  logic [WD_W-1:0]   wdata,
    output logic [CODE_W-1:0] tx_code,
    output logic [CODE_W-1:0] rx_code,
    output logic [SRC_N-1:0]  mask,
    output logic [WD_W-1:0]   tmo_lim
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_code <= TXC_RST;
            rx_code <= RXC_RST;
            mask    <= '1;
            tmo_lim <= WD_W'(TMO_RST);
        end else begin
            if (thr_we) begin
                tx_code <= wdata[TXC_LSB +: CODE_W];
                rx_code <= wdata[RXC_LSB +: CODE_W];
            end
            if (mask_we) begin
                mask <= wdata[SRC_N-1:0];
            end
            if (tmo_we) begin
                tmo_lim <= wdata;
            end
        end
    end

endmodule

// File: rtl/spi_irq_sticky.sv
`timescale 1ns/1ps
module spi_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Set has priority over a clear at the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_irq_rxtmo.sv
`timescale 1ns/1ps
module spi_irq_rxtmo
    import spi_irq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_nonempty,
    input  logic             rx_push,
    input  logic [TMO_W-1:0] lim,
    output logic             fire
);

    localparam int CW = TMO_W + 1;

    tmo_state_e       st_q, st_d;
    logic [TMO_W-1:0] cnt_q, cnt_d;
    logic             quiet;
    logic             expire;

    assign quiet  = rx_nonempty && !rx_push;
    assign expire = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, lim};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TM_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!rx_nonempty) begin
            st_d  = TM_EMPTY;
            cnt_d = '0;
        end else if (rx_push) begin
            st_d  = TM_ARMED;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TM_EMPTY, TM_ARMED: begin
                    if (expire) begin
                        st_d  = TM_FIRED;
                        cnt_d = '0;
                    end else begin
                        st_d  = TM_ARMED;
                        cnt_d = cnt_q + TMO_W'(1);
                    end
                end
                TM_FIRED: begin
                    st_d = TM_FIRED;
                end
                default: begin
                    st_d  = TM_EMPTY;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        fire = quiet && (st_q != TM_FIRED) && expire;
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
`timescale 1ns/1ps
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter  int DEPTH   = 256,
    parameter  int WD_W    = 16,
    parameter  int TMO_RST = 32,
    localparam int LVL_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_push,
    input  logic              rx_overflow,
    input  logic              busy,
    input  logic              thr_we,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic              tmo_we,
    input  logic [WD_W-1:0]   wdata,
    output logic [SRC_N-1:0]  raw_stat,
    output logic [SRC_N-1:0]  irq_stat,
    output logic [SRC_N-1:0]  mask_q,
    output logic [4:0]        stat,
    output logic              irq
);

    localparam int STICKY_N = 2;

    logic [CODE_W-1:0]   tx_code, rx_code;
    logic [WD_W-1:0]     tmo_lim;
    logic                tmo_fire;
    logic [STICKY_N-1:0] sticky_set, sticky_clr, sticky_q;
    logic                tx_hit, rx_hit;

    spi_irq_cfg #(.WD_W(WD_W), .TMO_RST(TMO_RST)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_we  (thr_we),
        .mask_we (mask_we),
        .tmo_we  (tmo_we),
        .wdata   (wdata),
        .tx_code (tx_code),
        .rx_code (rx_code),
        .mask    (mask_q),
        .tmo_lim (tmo_lim)
    );

    spi_irq_rxtmo #(.TMO_W(WD_W)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_nonempty (rx_level != '0),
        .rx_push     (rx_push),
        .lim         (tmo_lim),
        .fire        (tmo_fire)
    );

    assign sticky_set = {tmo_fire, rx_overflow};
    assign sticky_clr = {STICKY_N{clr_we}} & wdata[STICKY_N-1:0];

    for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
        spi_irq_sticky u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (sticky_set[g]),
            .clr   (sticky_clr[g]),
            .q     (sticky_q[g])
        );
    end

    assign tx_hit = 32'(tx_level) <= thr_entries(tx_code);
    assign rx_hit = 32'(rx_level) >= thr_entries(rx_code);

    always_comb begin
        raw_stat           = '0;
        raw_stat[SRC_ROVF] = sticky_q[0];
        raw_stat[SRC_RTMO] = sticky_q[1];
        raw_stat[SRC_RLVL] = rx_hit;
        raw_stat[SRC_TLVL] = tx_hit;
        irq_stat           = raw_stat & ~mask_q;
        irq                = |irq_stat;
    end

    always_comb begin
        stat[0] = (tx_level == '0);
        stat[1] = (tx_level != LVL_W'(DEPTH));
        stat[2] = (rx_level != '0);
        stat[3] = (rx_level == LVL_W'(DEPTH));
        stat[4] = busy;
    end

endmodule

// File: rtl/spi_irq_ctrl_chk.sv
`timescale 1ns/1ps
module spi_irq_ctrl_chk #(
    parameter  int DEPTH = 256,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_push,
    input logic             rx_overflow,
    input logic             mask_we,
    input logic             clr_we,
    input logic [3:0]       wdata_lo,
    input logic [3:0]       raw_stat,
    input logic [3:0]       mask_q,
    input logic             irq
);

    p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> raw_stat[0]);

    p_ovf_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata_lo[0] && !rx_overflow) |=> !raw_stat[0]);

    p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[0] && !(clr_we && wdata_lo[0])) |=> raw_stat[0]);

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata_lo)));

    p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'hF) |-> !irq);

    p_tmo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_stat[1]) |-> $past((rx_level != '0) && !rx_push));

endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .rx_push     (rx_push),
    .rx_overflow (rx_overflow),
    .mask_we     (mask_we),
    .clr_we      (clr_we),
    .wdata_lo    (wdata[3:0]),
    .raw_stat    (raw_stat),
    .mask_q      (mask_q),
    .irq         (irq)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;

    localparam int DEPTH = 256;
    localparam int LVL_W = 9;
    localparam int WD_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             rx_push, rx_overflow, busy;
    logic             thr_we, mask_we, clr_we, tmo_we;
    logic [WD_W-1:0]  wdata;
    logic [3:0]       raw_stat, irq_stat, mask_q;
    logic [4:0]       stat;
    logic             irq;

    always #2.5 clk = ~clk;

    spi_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .rx_push(rx_push), .rx_overflow(rx_overflow), .busy(busy),
        .thr_we(thr_we), .mask_we(mask_we), .clr_we(clr_we), .tmo_we(tmo_we),
        .wdata(wdata), .raw_stat(raw_stat), .irq_stat(irq_stat),
        .mask_q(mask_q), .stat(stat), .irq(irq)
    );

    int   nvec = 0;
    int   nerr = 0;
    bit   done = 1'b0;

    // Bench model state
    bit         m_of, m_to, m_fired;
    logic [3:0] m_mask;
    logic [2:0] m_txc, m_rxc;
    int         m_lim, m_cnt;

    function automatic int entries(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            3'd5: return 64;
            3'd6: return 128;
            default: return 256;
        endcase
    endfunction

    function automatic logic [3:0] exp_raw();
        logic [3:0] r;
        r[0] = m_of;
        r[1] = m_to;
        r[2] = (int'(rx_level) >= entries(m_rxc));
        r[3] = (int'(tx_level) <= entries(m_txc));
        return r;
    endfunction

    function automatic logic [4:0] exp_stat();
        logic [4:0] s;
        s[0] = (tx_level == 0);
        s[1] = (int'(tx_level) != DEPTH);
        s[2] = (rx_level != 0);
        s[3] = (int'(rx_level) == DEPTH);
        s[4] = busy;
        return s;
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [3:0] r;
        r = exp_raw();
        nvec++;
        expect_eq("R5", "raw overflow bit", 32'(raw_stat[0]), 32'(r[0]));
        expect_eq("R9", "raw timeout bit", 32'(raw_stat[1]), 32'(r[1]));
        expect_eq("R8", "raw rx level bit", 32'(raw_stat[2]), 32'(r[2]));
        expect_eq("R7", "raw tx level bit", 32'(raw_stat[3]), 32'(r[3]));
        expect_eq("R2", "mask_q", 32'(mask_q), 32'(m_mask));
        expect_eq("R2", "irq_stat", 32'(irq_stat), 32'(r & ~m_mask));
        expect_eq("R3", "irq", 32'(irq), 32'(|(r & ~m_mask)));
        expect_eq("R11", "stat", 32'(stat), 32'(exp_stat()));
    endtask

    task automatic model_reset();
        m_of = 0; m_to = 0; m_fired = 0; m_cnt = 0;
        m_mask = 4'hF; m_txc = 3'd5; m_rxc = 3'd3; m_lim = 32;
    endtask

    task automatic model_edge();
        bit quiet, to_set;
        quiet  = (rx_level != 0) && !rx_push;
        to_set = quiet && !m_fired && (m_cnt + 1 >= m_lim);
        if (!quiet) begin
            m_cnt = 0; m_fired = 0;
        end else if (!m_fired) begin
            if (m_cnt + 1 >= m_lim) begin
                m_fired = 1; m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (rx_overflow) m_of = 1;
        else if (clr_we && wdata[0]) m_of = 0;
        if (to_set) m_to = 1;
        else if (clr_we && wdata[1]) m_to = 0;
        if (thr_we) begin
            m_txc = wdata[5:3];
            m_rxc = wdata[11:9];
        end
        if (mask_we) m_mask = wdata[3:0];
        if (tmo_we) m_lim = int'(wdata);
    endtask

    task automatic idle_in();
        rx_push = 0; rx_overflow = 0; busy = 0;
        thr_we = 0; mask_we = 0; clr_we = 0; tmo_we = 0; wdata = '0;
    endtask

    // Inputs are set just after a falling edge; check, then advance one edge.
    task automatic cycle();
        #1;
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        tx_level = '0; rx_level = '0;
        idle_in();
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        expect_eq("R1", "mask_q reset", 32'(mask_q), 32'hF);
        expect_eq("R1", "sticky reset", 32'(raw_stat[1:0]), 32'h0);
        expect_eq("R1", "irq reset", 32'(irq), 32'h0);
        check_all();
        @(negedge clk);
        rst_n = 1;

        // R1/R9: default limit 32, fires on the 32nd quiet edge
        rx_level = 9'd1;
        for (int i = 0; i < 31; i++) cycle();
        #1 expect_eq("R1", "timeout not yet at 31", 32'(raw_stat[1]), 32'h0);
        cycle();
        #1 expect_eq("R1", "timeout at 32 quiet edges", 32'(raw_stat[1]), 32'h1);
        idle_in(); clr_we = 1; wdata = 16'h0002; cycle();
        idle_in();
        for (int i = 0; i < 40; i++) cycle();
        #1 expect_eq("R9", "no refire without push", 32'(raw_stat[1]), 32'h0);

        // R10: programmed limit 6
        tmo_we = 1; wdata = 16'd6; cycle();
        idle_in(); rx_level = 9'd5; rx_push = 1; cycle();
        rx_push = 0;
        for (int i = 0; i < 5; i++) cycle();
        #1 expect_eq("R10", "limit 6, after 5 quiet", 32'(raw_stat[1]), 32'h0);
        cycle();
        #1 expect_eq("R10", "limit 6, after 6 quiet", 32'(raw_stat[1]), 32'h1);
        clr_we = 1; wdata = 16'h0002; cycle();
        idle_in(); rx_push = 1; cycle();
        rx_push = 0;
        for (int i = 0; i < 6; i++) cycle();
        #1 expect_eq("R9", "refire after push", 32'(raw_stat[1]), 32'h1);

        // R5: set and clear at the same edge, set wins
        idle_in(); rx_level = '0;
        rx_overflow = 1; clr_we = 1; wdata = 16'h0003; cycle();
        idle_in();
        #1 expect_eq("R5", "set beats clear", 32'(raw_stat[0]), 32'h1);
        cycle();
        #1 expect_eq("R5", "overflow holds", 32'(raw_stat[0]), 32'h1);
        // R4: clear acts on sticky bits only
        tx_level = '0; clr_we = 1; wdata = 16'h000F; cycle();
        idle_in();
        #1 expect_eq("R4", "overflow cleared", 32'(raw_stat[0]), 32'h0);
        expect_eq("R4", "tx level bit untouched", 32'(raw_stat[3]), 32'h1);

        // R6: every code, levels around the entry count
        for (int c = 0; c < 8; c++) begin
            idle_in(); thr_we = 1; wdata = 16'((c << 3) | (c << 9)); cycle();
            idle_in();
            for (int d = -1; d <= 1; d++) begin
                int lv;
                lv = entries(3'(c)) + d;
                if (lv < 0) lv = 0;
                if (lv > DEPTH) lv = DEPTH;
                tx_level = 9'(lv); rx_level = 9'(lv);
                #1;
                expect_eq("R6", "tx threshold decode", 32'(raw_stat[3]),
                          32'(lv <= entries(3'(c))));
                expect_eq("R6", "rx threshold decode", 32'(raw_stat[2]),
                          32'(lv >= entries(3'(c))));
                cycle();
            end
        end

        // R2/R3: unmask all, then random traffic
        idle_in(); mask_we = 1; wdata = 16'h0000; cycle();
        idle_in(); tmo_we = 1; wdata = 16'd4; cycle();
        for (int n = 0; n < 4000; n++) begin
            int k;
            idle_in();
            k = int'($urandom % 4);
            tx_level = (k == 0) ? 9'd0 : (k == 1) ? 9'(DEPTH) :
                       (k == 2) ? 9'($urandom % (DEPTH + 1)) : 9'($urandom % 10);
            k = int'($urandom % 4);
            rx_level = (k == 0) ? 9'd0 : (k == 1) ? 9'(DEPTH) :
                       (k == 2) ? 9'($urandom % (DEPTH + 1)) : 9'(1 + $urandom % 20);
            if ((n / 50) % 2 == 1 && rx_level == 0) rx_level = 9'd3;
            rx_push     = ($urandom % 12) == 0;
            rx_overflow = ($urandom % 20) == 0;
            busy        = 1'($urandom);
            wdata       = 16'($urandom);
            thr_we      = ($urandom % 10) == 0;
            mask_we     = ($urandom % 10) == 0;
            clr_we      = ($urandom % 6) == 0;
            tmo_we      = ($urandom % 25) == 0;
            if (tmo_we) wdata = 16'(1 + $urandom % 12);
            cycle();
        end

        // R11: full FIFOs
        idle_in(); tx_level = 9'(DEPTH); rx_level = 9'(DEPTH); busy = 1;
        #1 expect_eq("R11", "full status", 32'(stat), 32'h1C);
        cycle();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule